// File: doc/BRIEF.md
# Chip-Select-Limited Burst Splitter

This block sits between a requester that wants one long linear transfer from a self-refreshing serial DRAM and the bus engine that drives the actual device transaction. The requester hands over a start byte address, a byte count and a direction. The block turns this into a series of shorter transactions. Each one keeps chip select low for no longer than the device allows, and none runs across a 1024-byte row. The device can then refresh its rows between transactions, and no transaction hits a row-boundary stall or wrap.

The chip-select time limit is expressed as a maximum byte count per transaction. Two such budgets are supplied: a tight one for the default refresh interval and a relaxed one for the longer interval. A select input picks between them. For each segment the block offers an address, a length and a direction to the bus engine. It waits for the engine to accept the segment and to report it finished. It then holds off for a configured number of idle cycles before it offers the next segment. After the last segment it pulses completion back to the requester. Bus waveforms, latency and data movement belong to the bus engine.

Top module: `cs_burst_splitter`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `seg_valid` is 0 and `done` is 0.
- R2: Every segment length equals the smallest of three values: the held budget, the bytes left before the next 1024-byte row boundary (1024 − (address mod 1024)), and the bytes still remaining. The held budget is `cfg_budget_long` when `cfg_relaxed` is 1 and `cfg_budget_short` when it is 0. A budget of 0 acts as 1.
- R3: No segment crosses a row boundary: (seg_addr mod 1024) + seg_len ≤ 1024.
- R4: The first segment starts at `req_addr`. Each later segment starts at the previous address plus the previous length, modulo 2^ADDR_W. The lengths add up to `req_len`, and every segment carries `req_write` on `seg_write`.
- R5: While `seg_valid` is 1 and `seg_ready` is 0, `seg_valid`, `seg_addr`, `seg_len` and `seg_write` hold steady. `seg_valid` drops the cycle after the handshake.
- R6: When `seg_done` ends a segment and bytes remain, `seg_valid` stays 0 for exactly G cycles and then rises. G is `cfg_gap_cycles` as sampled with `seg_done`.
- R7: `done` is 1 for exactly one cycle, the cycle after `seg_done` of the final segment. `req_ready` is 1 in that same cycle.
- R8: A request with `req_len` = 0 issues no segment. It raises `done` in the cycle after it is accepted.
- R9: `req_ready` is 0 from the cycle after a non-zero request is accepted until `done`. A `req_valid` during that time is ignored.
- R10: For a non-zero request, `seg_valid` is 1 in the cycle after acceptance.
- R11: The budget is captured when the request is accepted. Changes to `cfg_budget_short`, `cfg_budget_long` or `cfg_relaxed` during a transfer do not alter its segment lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester offers a transfer |
| req_ready | output | 1 | Block is idle and accepts a transfer |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count, 0 allowed |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_budget_short | input | MAXB_W | Byte budget for the tight chip-select limit |
| cfg_budget_long | input | MAXB_W | Byte budget for the relaxed chip-select limit |
| cfg_relaxed | input | 1 | Selects the relaxed budget |
| cfg_gap_cycles | input | GAP_W | Minimum idle cycles between segments |
| seg_valid | output | 1 | Segment offered to the bus engine |
| seg_ready | input | 1 | Bus engine accepts the segment |
| seg_addr | output | ADDR_W | Segment start byte address |
| seg_len | output | LEN_W | Segment byte count |
| seg_write | output | 1 | Segment direction |
| seg_done | input | 1 | Bus engine finished the accepted segment |
| done | output | 1 | One-cycle pulse when the whole transfer is finished |

## Verification
The first segment is due one cycle after acceptance. A zero-length request shows `done` one cycle after acceptance. A handshaken segment withdraws `seg_valid` on the next cycle. After a non-final `seg_done`, exactly `cfg_gap_cycles` idle cycles pass before the next offer. After the final `seg_done`, `done` shows on the next cycle and lasts one cycle. The bench drives inputs on the falling edge. It samples on the falling edge that follows the rising edge where each result is due, and counts the gap cycles one falling edge at a time. It sweeps budgets, start offsets around and across row edges (including address wrap), lengths, both budget selections, gap lengths and acceptance delays. Each expected length comes from its own minimum calculation.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_BUSY  = 2'd2,
    ST_GAP   = 2'd3
  } cbs_state_e;

endpackage

// File: rtl/cbs_budget_sel.sv
module cbs_budget_sel #(
  parameter int MAXB_W = 12
) (
  input  logic              relaxed,
  input  logic [MAXB_W-1:0] short_bytes,
  input  logic [MAXB_W-1:0] long_bytes,
  output logic [MAXB_W-1:0] budget
);

  function automatic logic [MAXB_W-1:0] floor_one(input logic [MAXB_W-1:0] b);
    return (b == '0) ? MAXB_W'(1) : b;
  endfunction

  logic [MAXB_W-1:0] picked;

  always_comb begin
    picked = relaxed ? long_bytes : short_bytes;
    budget = floor_one(picked);
  end

endmodule

// File: rtl/cbs_seg_calc.sv
module cbs_seg_calc #(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int MAXB_W    = 12,
  parameter int ROW_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remaining,
  input  logic [MAXB_W-1:0] budget,
  output logic [LEN_W-1:0]  seg_len,
  output logic              row_limited
);

  localparam int ROW_W = $clog2(ROW_BYTES);
  localparam int CW    = ((LEN_W > MAXB_W) ? LEN_W : MAXB_W) + 2;

  function automatic logic [CW-1:0] room_in_row(input logic [ROW_W-1:0] offs);
    return CW'(ROW_BYTES) - CW'(offs);
  endfunction

  function automatic logic [CW-1:0] min2(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [CW-1:0] room_w;
  logic [CW-1:0] budget_w;
  logic [CW-1:0] rem_w;
  logic [CW-1:0] cap_w;
  logic [CW-1:0] len_w;

  always_comb begin
    room_w      = room_in_row(addr[ROW_W-1:0]);
    budget_w    = CW'(budget);
    rem_w       = CW'(remaining);
    cap_w       = min2(budget_w, room_w);
    len_w       = min2(cap_w, rem_w);
    row_limited = (room_w < budget_w) && (room_w < rem_w);
    seg_len     = LEN_W'(len_w);
  end

endmodule

// File: rtl/cbs_gap_timer.sv
module cbs_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             last
);

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - GAP_W'(1);
    end
  end

  assign last = (cnt_q == GAP_W'(1));

endmodule

// File: rtl/cs_burst_splitter.sv
module cs_burst_splitter #(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int MAXB_W    = 12,
  parameter int GAP_W     = 4,
  parameter int ROW_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic [MAXB_W-1:0] cfg_budget_short,
  input  logic [MAXB_W-1:0] cfg_budget_long,
  input  logic              cfg_relaxed,
  input  logic [GAP_W-1:0]  cfg_gap_cycles,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_write,
  input  logic              seg_done,
  output logic              done
);

  import cbs_pkg::*;

  cbs_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              wr_q;
  logic [MAXB_W-1:0] bud_q;
  logic              done_q;

  // named internal events
  logic              accept_evt;
  logic              accept_zero;
  logic              seg_fire;
  logic              seg_end;
  logic              bytes_left;
  logic              gap_needed;
  logic              gap_last;
  logic              row_limited;
  logic [MAXB_W-1:0] budget_now;
  logic [LEN_W-1:0]  next_len;

  cbs_budget_sel #(.MAXB_W(MAXB_W)) u_bsel (
    .relaxed     (cfg_relaxed),
    .short_bytes (cfg_budget_short),
    .long_bytes  (cfg_budget_long),
    .budget      (budget_now)
  );

  cbs_seg_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAXB_W(MAXB_W), .ROW_BYTES(ROW_BYTES)
  ) u_calc (
    .addr        (addr_q),
    .remaining   (rem_q),
    .budget      (bud_q),
    .seg_len     (next_len),
    .row_limited (row_limited)
  );

  assign accept_evt  = req_valid && (state_q == ST_IDLE);
  assign accept_zero = accept_evt && (req_len == '0);
  assign seg_fire    = (state_q == ST_OFFER) && seg_ready;
  assign seg_end     = (state_q == ST_BUSY) && seg_done;
  assign bytes_left  = (rem_q != '0);
  assign gap_needed  = (cfg_gap_cycles != '0);

  cbs_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seg_end),
    .load_val (cfg_gap_cycles),
    .last     (gap_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      wr_q    <= 1'b0;
      bud_q   <= MAXB_W'(1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            addr_q <= req_addr;
            rem_q  <= req_len;
            wr_q   <= req_write;
            bud_q  <= budget_now;
            if (accept_zero) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_OFFER;
            end
          end
        end
        ST_OFFER: begin
          if (seg_fire) begin
            addr_q  <= addr_q + ADDR_W'(next_len);
            rem_q   <= rem_q - next_len;
            state_q <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (seg_end) begin
            if (!bytes_left) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (gap_needed) begin
              state_q <= ST_GAP;
            end else begin
              state_q <= ST_OFFER;
            end
          end
        end
        ST_GAP: begin
          if (gap_last) begin
            state_q <= ST_OFFER;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign seg_valid = (state_q == ST_OFFER);
  assign seg_addr  = addr_q;
  assign seg_len   = next_len;
  assign seg_write = wr_q;
  assign done      = done_q;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int MAXB_W    = 12,
  parameter int GAP_W     = 4,
  parameter int ROW_BYTES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic [GAP_W-1:0]  cfg_gap_cycles,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [ADDR_W-1:0] seg_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic              seg_write,
  input logic              seg_done,
  input logic              done,
  input logic [MAXB_W-1:0] bud_q,
  input logic              bytes_left
);

  localparam int ROW_W = $clog2(ROW_BYTES);

  logic             pend_q;
  logic             watch_q;
  logic [GAP_W:0]   idle_q;
  logic [GAP_W-1:0] gref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      watch_q <= 1'b0;
      idle_q  <= '0;
      gref_q  <= '0;
    end else begin
      if (seg_valid && seg_ready) pend_q <= 1'b1;
      else if (seg_done)          pend_q <= 1'b0;
      if (pend_q && seg_done && bytes_left) begin
        watch_q <= 1'b1;
        idle_q  <= '0;
        gref_q  <= cfg_gap_cycles;
      end else if (watch_q) begin
        if (seg_valid) watch_q <= 1'b0;
        else if (idle_q != '1) idle_q <= idle_q + 1'b1;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> (req_ready && !seg_valid && !done));

  assert_len_within_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0) && (32'(seg_len) <= 32'(bud_q)));

  assert_no_row_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (32'(seg_addr[ROW_W-1:0]) + 32'(seg_len) <= 32'(ROW_BYTES)));

  assert_offer_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_write)));

  assert_offer_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready) |=> !seg_valid);

  assert_gap_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_q && seg_valid) |-> (idle_q == {1'b0, gref_q}));

  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_zero_len_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0)) |=> (done && !seg_valid));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid || pend_q) |-> !req_ready);

  assert_first_offer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len != '0)) |=> seg_valid);

endmodule

bind cs_burst_splitter cbs_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAXB_W(MAXB_W), .GAP_W(GAP_W), .ROW_BYTES(ROW_BYTES)
) u_cbs_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_len        (req_len),
  .cfg_gap_cycles (cfg_gap_cycles),
  .seg_valid      (seg_valid),
  .seg_ready      (seg_ready),
  .seg_addr       (seg_addr),
  .seg_len        (seg_len),
  .seg_write      (seg_write),
  .seg_done       (seg_done),
  .done           (done),
  .bud_q          (bud_q),
  .bytes_left     (bytes_left)
);

// File: tb/cs_burst_splitter_test.sv
module cs_burst_splitter_test;

  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;
  localparam int MAXB_W = 12;
  localparam int GAP_W  = 4;
  localparam int ROWB   = 1024;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              req_write;
  logic [MAXB_W-1:0] cfg_budget_short;
  logic [MAXB_W-1:0] cfg_budget_long;
  logic              cfg_relaxed;
  logic [GAP_W-1:0]  cfg_gap_cycles;
  logic              seg_valid;
  logic              seg_ready;
  logic [ADDR_W-1:0] seg_addr;
  logic [LEN_W-1:0]  seg_len;
  logic              seg_write;
  logic              seg_done;
  logic              done;

  cs_burst_splitter uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write),
    .cfg_budget_short(cfg_budget_short), .cfg_budget_long(cfg_budget_long),
    .cfg_relaxed(cfg_relaxed), .cfg_gap_cycles(cfg_gap_cycles),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_write(seg_write), .seg_done(seg_done), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int expect_len(input int a, input int rem, input int bud);
    int lim;
    int row_room;
    lim      = (bud == 0) ? 1 : bud;
    row_room = ROWB - (a % ROWB);
    if (row_room < lim) lim = row_room;
    if (rem < lim)      lim = rem;
    return lim;
  endfunction

  task automatic run(input int a, input int len, input bit wr, input int bs, input int bl,
                     input bit rlx, input int gap, input int rdly);
    int ea;
    int erem;
    int elen;
    int bud;
    @(negedge clk);
    req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(len); req_write = wr;
    cfg_budget_short = MAXB_W'(bs); cfg_budget_long = MAXB_W'(bl);
    cfg_relaxed = rlx; cfg_gap_cycles = GAP_W'(gap);
    chk(req_ready == 1'b1, "R9 ready while idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    // R11: scramble the budget inputs after acceptance
    cfg_budget_short = MAXB_W'(3); cfg_budget_long = MAXB_W'(2); cfg_relaxed = ~rlx;
    bud  = rlx ? bl : bs;
    ea   = a;
    erem = len;
    if (len == 0) begin
      chk(done == 1'b1, "R8 zero-length done", done, 1);
      chk(seg_valid == 1'b0, "R8 zero-length no segment", seg_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", done, 0);
      return;
    end
    chk(req_ready == 1'b0, "R9 busy after accept", req_ready, 0);
    while (erem > 0) begin
      elen = expect_len(ea, erem, bud);
      chk(seg_valid == 1'b1, "R10/R6 segment offered", seg_valid, 1);
      chk(int'(seg_addr) == ea, "R4 segment address", seg_addr, ea);
      chk(int'(seg_len) == elen, "R2/R11 segment length", seg_len, elen);
      chk(seg_write == wr, "R4 segment direction", seg_write, wr);
      chk((int'(seg_addr) % ROWB) + int'(seg_len) <= ROWB, "R3 row boundary",
          (int'(seg_addr) % ROWB) + int'(seg_len), ROWB);
      for (int k = 0; k < rdly; k++) begin
        @(negedge clk);
        chk(seg_valid && int'(seg_addr) == ea && int'(seg_len) == elen, "R5 held offer",
            seg_len, elen);
      end
      seg_ready = 1'b1;
      @(negedge clk);
      seg_ready = 1'b0;
      ea   = (ea + elen) & AMASK;
      erem = erem - elen;
      chk(seg_valid == 1'b0, "R5 offer withdrawn", seg_valid, 0);
      req_valid = 1'b1; req_len = LEN_W'(7);
      chk(req_ready == 1'b0, "R9 busy ignores request", req_ready, 0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R9 busy ignores request", req_ready, 0);
      req_valid = 1'b0;
      seg_done = 1'b1;
      @(negedge clk);
      seg_done = 1'b0;
      if (erem == 0) begin
        chk(done == 1'b1, "R7 done after last segment", done, 1);
        chk(req_ready == 1'b1, "R7 ready with done", req_ready, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", done, 0);
      end else begin
        chk(done == 1'b0, "R7 no early done", done, 0);
        for (int k = 0; k < gap; k++) begin
          chk(seg_valid == 1'b0, "R6 idle gap", seg_valid, 0);
          @(negedge clk);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int budgets [6] = '{0, 1, 7, 100, 1024, 3000};
    int offsets [6] = '{0, 1, 1000, 1023, 3572, 24'hFFFFF0};
    int lengths [6] = '{0, 1, 5, 37, 1030, 2500};
    int idx;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_write = 1'b0;
    cfg_budget_short = '0; cfg_budget_long = '0; cfg_relaxed = 1'b0; cfg_gap_cycles = '0;
    seg_ready = 1'b0; seg_done = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(seg_valid == 1'b0, "R1 reset no segment", seg_valid, 0);
    chk(done == 1'b0, "R1 reset no done", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && seg_valid == 1'b0 && done == 1'b0, "R1 after reset",
        {req_ready, seg_valid, done}, 3'b100);
    idx = 0;
    for (int bi = 0; bi < 6; bi++) begin
      for (int oi = 0; oi < 6; oi++) begin
        for (int li = 0; li < 6; li++) begin
          for (int r = 0; r < 2; r++) begin
            if (budgets[bi] < 8 && lengths[li] > 37) continue;
            if (r == 1)
              run(offsets[oi], lengths[li], idx[0], 9, budgets[bi], 1'b1, idx % 4, idx % 2);
            else
              run(offsets[oi], lengths[li], idx[1], budgets[bi], 500, 1'b0, idx % 4, (idx / 2) % 2);
            idx++;
          end
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule